// File: doc/BRIEF.md
# Resource Utilization Monitor

This block watches one shared resource. Each cycle it sees a busy flag and the resource's current memory occupancy. It counts the cycles in which the resource was busy within a measurement window. It also keeps the current and the highest occupancy seen. Software reads the counters and forms the percentages itself.

The window can be defined in two ways, and the mode is chosen when a measurement starts:

- **Event window.** The window runs from a start pulse to a stop pulse. Idle time before and after the activity counts against the result.
- **Span window.** The window runs from the first busy cycle to the last one. A resource used in one burst therefore reports a window equal to the burst.

A stop pulse freezes the results and raises a done flag until the next start.

Top module: `util_mon`

## Requirements
- R1: After reset the busy count, window length, current occupancy and peak occupancy all read zero and `done_o` is low.
- R2: A cycle with `start_i` high clears the busy count and window length, lowers `done_o` and begins a run; from the next cycle the outputs show the cleared values.
- R3: During a run, every cycle with `busy_i` high adds one to the busy count, and the cycle carrying `stop_i` is included. Busy cycles outside a run (idle or done) leave the count unchanged.
- R4: With mode 0 (event window), the window length is the number of run cycles, from the cycle after the start pulse through the stop cycle inclusive.
- R5: With mode 1 (span window), number the run cycles from 0. The window length is then the index of the last busy cycle minus the index of the first busy cycle, plus one. It reads zero when no busy cycle occurred.
- R6: The mode is captured in the start cycle and holds until the next start; changes on `mode_i` during a run have no effect.
- R7: The cycle carrying `stop_i` during a run ends the run. From then on `done_o` is high and the counts stay frozen until the next start. A stop outside a run is ignored.
- R8: The busy count and the window length stop at their all-ones value instead of wrapping, in both modes.
- R9: The current occupancy output is `min(occ_i, cap_i)` as it stood at the previous clock edge.
- R10: Peak occupancy holds the largest clamped occupancy seen since reset. At a start pulse it restarts at that cycle's clamped occupancy, and it is never below the current occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Resource in use this cycle |
| occ_i | input | OCC_W | Memory occupancy this cycle |
| cap_i | input | OCC_W | Memory capacity; occupancy is clamped to it |
| start_i | input | 1 | Begin a measurement, capture mode |
| stop_i | input | 1 | End the running measurement |
| mode_i | input | 1 | 0 = event window, 1 = first-to-last busy window |
| busy_cnt_o | output | CNT_W | Busy cycles in the window |
| win_len_o | output | CNT_W | Window length in cycles |
| peak_occ_o | output | OCC_W | Highest clamped occupancy |
| cur_occ_o | output | OCC_W | Clamped occupancy, one cycle delayed |
| done_o | output | 1 | Measurement ended, results frozen |

## Verification
The assertions assume that `rst_ni` is asserted before the first edge. They also assume that `cap_i` and `occ_i` are settled values at every edge, because the clamp and the peak checks compare against the capacity sampled one edge earlier. The freeze and monotonic-count properties assume that `start_i` is the only way to clear a measurement. The stimulus therefore changes inputs only on the falling edge. It pulses start for exactly one cycle, and it exercises the ignored-stop and ignored-busy cases only while no start is pending.

// File: rtl/util_mon_pkg.sv
package util_mon_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} run_state_e;
  typedef enum logic {WIN_EVENT = 1'b0, WIN_SPAN = 1'b1} win_mode_e;
endpackage

// File: rtl/util_win_ctrl.sv
module util_win_ctrl
  import util_mon_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      stop_i,
  input  logic      mode_i,
  output logic      run_o,
  output logic      done_o,
  output logic      clr_o,
  output win_mode_e mode_o
);
  run_state_e state_q;
  win_mode_e  mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= WIN_EVENT;
    end else if (start_i) begin
      state_q <= ST_RUN;
      mode_q  <= win_mode_e'(mode_i);
    end else if (state_q == ST_RUN && stop_i) begin
      state_q <= ST_DONE;
    end
  end

  // start dominates: the start cycle itself is not a run cycle
  assign run_o  = (state_q == ST_RUN) && !start_i;
  assign done_o = (state_q == ST_DONE);
  assign clr_o  = start_i;
  assign mode_o = mode_q;
endmodule

// File: rtl/util_sat_cnt.sv
module util_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CntMax = '1;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (inc_i && cnt_q != CntMax)  cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/util_span.sv
module util_span #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         hit_i,
  input  logic [W-1:0] ts_i,
  output logic [W-1:0] span_o
);
  logic         seen_q;
  logic [W-1:0] first_q, last_q;
  logic [W:0]   diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      first_q <= '0;
      last_q  <= '0;
    end else if (clr_i) begin
      seen_q  <= 1'b0;
      first_q <= '0;
      last_q  <= '0;
    end else if (hit_i) begin
      if (!seen_q) begin
        seen_q  <= 1'b1;
        first_q <= ts_i;
      end
      last_q <= ts_i;
    end
  end

  // one extra bit so that a full-range span clamps instead of wrapping
  assign diff = {1'b0, last_q} - {1'b0, first_q} + (W+1)'(1);

  always_comb begin
    if (!seen_q)      span_o = '0;
    else if (diff[W]) span_o = '1;
    else              span_o = diff[W-1:0];
  end
endmodule

// File: rtl/util_occ_track.sv
module util_occ_track #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic [W-1:0] occ_i,
  input  logic [W-1:0] cap_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] peak_o
);
  logic [W-1:0] occ_c, cur_q, peak_q;

  assign occ_c = (occ_i > cap_i) ? cap_i : occ_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      peak_q <= '0;
    end else begin
      cur_q <= occ_c;
      if (restart_i || occ_c > peak_q) peak_q <= occ_c;
    end
  end

  assign cur_o  = cur_q;
  assign peak_o = peak_q;
endmodule

// File: rtl/util_mon.sv
module util_mon
  import util_mon_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int OCC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic [OCC_W-1:0] occ_i,
  input  logic [OCC_W-1:0] cap_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             mode_i,
  output logic [CNT_W-1:0] busy_cnt_o,
  output logic [CNT_W-1:0] win_len_o,
  output logic [OCC_W-1:0] peak_occ_o,
  output logic [OCC_W-1:0] cur_occ_o,
  output logic             done_o
);
  logic             run, clr, hit;
  win_mode_e        mode;
  logic [CNT_W-1:0] win_cnt, span_len;

  util_win_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .stop_i (stop_i),
    .mode_i (mode_i),
    .run_o  (run),
    .done_o (done_o),
    .clr_o  (clr),
    .mode_o (mode)
  );

  assign hit = run && busy_i;

  util_sat_cnt #(.W(CNT_W)) u_busy_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .inc_i (hit),
    .cnt_o (busy_cnt_o)
  );

  // run-cycle counter: event window length and span timestamp
  util_sat_cnt #(.W(CNT_W)) u_win_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .inc_i (run),
    .cnt_o (win_cnt)
  );

  util_span #(.W(CNT_W)) u_span (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .hit_i (hit),
    .ts_i  (win_cnt),
    .span_o(span_len)
  );

  util_occ_track #(.W(OCC_W)) u_occ (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(start_i),
    .occ_i    (occ_i),
    .cap_i    (cap_i),
    .cur_o    (cur_occ_o),
    .peak_o   (peak_occ_o)
  );

  assign win_len_o = (mode == WIN_SPAN) ? span_len : win_cnt;
endmodule

// File: rtl/util_mon_chk.sv
module util_mon_chk #(
  parameter int CNT_W = 16,
  parameter int OCC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [OCC_W-1:0] cap_i,
  input logic             start_i,
  input logic [CNT_W-1:0] busy_cnt_o,
  input logic [CNT_W-1:0] win_len_o,
  input logic [OCC_W-1:0] peak_occ_o,
  input logic [OCC_W-1:0] cur_occ_o,
  input logic             done_o
);
  assert_start_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done_o && busy_cnt_o == '0));

  assert_done_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(busy_cnt_o) && $stable(win_len_o)));

  assert_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (busy_cnt_o >= $past(busy_cnt_o)));

  assert_occ_clamped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cur_occ_o <= $past(cap_i)));

  assert_peak_bounds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peak_occ_o >= cur_occ_o);
endmodule

bind util_mon util_mon_chk #(.CNT_W(CNT_W), .OCC_W(OCC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cap_i     (cap_i),
  .start_i   (start_i),
  .busy_cnt_o(busy_cnt_o),
  .win_len_o (win_len_o),
  .peak_occ_o(peak_occ_o),
  .cur_occ_o (cur_occ_o),
  .done_o    (done_o)
);

// File: tb/util_mon_tb.sv
module util_mon_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int OCC_W = 8;
  localparam int NVEC  = 8;

  // event/span vectors: mode, busy pattern (bit k = run cycle k), expected busy, expected window
  localparam logic       V_MODE [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic [7:0] V_PAT  [NVEC] = '{8'h00, 8'hFF, 8'h3C, 8'h3C, 8'h00, 8'h81, 8'h10, 8'h52};
  localparam int         V_BUSY [NVEC] = '{0, 8, 4, 4, 0, 2, 1, 3};
  localparam int         V_WIN  [NVEC] = '{8, 8, 8, 4, 0, 8, 1, 6};

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             busy_i = 1'b0, start_i = 1'b0, stop_i = 1'b0, mode_i = 1'b0;
  logic [OCC_W-1:0] occ_i = '0, cap_i = '0;
  logic [CNT_W-1:0] busy_cnt_o, win_len_o;
  logic [OCC_W-1:0] peak_occ_o, cur_occ_o;
  logic             done_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  util_mon #(.CNT_W(CNT_W), .OCC_W(OCC_W)) u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // start with mode m0, hold mode m1 during the run, n run cycles, stop on the last
  task automatic run_win(input logic m0, input logic m1, input logic [15:0] pat, input int n);
    @(negedge clk_i);
    start_i = 1'b1; mode_i = m0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      start_i = 1'b0; mode_i = m1;
      busy_i = (k < 16) ? pat[k] : pat[15];
      stop_i = (k == n - 1);
    end
    @(negedge clk_i);
    busy_i = 1'b0; stop_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 busy", busy_cnt_o, 0);
    chk("R1 win", win_len_o, 0);
    chk("R1 peak", peak_occ_o, 0);
    chk("R1 cur", cur_occ_o, 0);
    chk("R1 done", done_o, 0);

    // R3: busy while idle is not counted
    busy_i = 1'b1;
    repeat (3) @(negedge clk_i);
    busy_i = 1'b0;
    chk("R3 idle busy ignored", busy_cnt_o, 0);

    // R4 R5: table of windows
    for (int v = 0; v < NVEC; v++) begin
      run_win(V_MODE[v], V_MODE[v], {8'h00, V_PAT[v]}, 8);
      chk($sformatf("R3 busy v%0d", v), busy_cnt_o, V_BUSY[v]);
      chk(V_MODE[v] ? $sformatf("R5 span v%0d", v) : $sformatf("R4 event v%0d", v),
          win_len_o, V_WIN[v]);
      chk($sformatf("R7 done v%0d", v), done_o, 1);
    end

    // R7 R3: busy and stop after done change nothing
    busy_i = 1'b1; stop_i = 1'b1;
    repeat (5) @(negedge clk_i);
    busy_i = 1'b0; stop_i = 1'b0;
    chk("R7 frozen busy", busy_cnt_o, 3);
    chk("R7 frozen win", win_len_o, 6);
    chk("R7 still done", done_o, 1);

    // R2: start clears
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R2 busy cleared", busy_cnt_o, 0);
    chk("R2 win cleared", win_len_o, 0);
    chk("R2 done low", done_o, 0);
    stop_i = 1'b1;
    @(negedge clk_i);
    stop_i = 1'b0;

    // R6: mode captured at start, input change mid-run ignored
    run_win(1'b1, 1'b0, 16'h0008, 8);
    chk("R6 span kept", win_len_o, 1);
    run_win(1'b0, 1'b1, 16'h0008, 8);
    chk("R6 event kept", win_len_o, 8);

    // R8: saturation in both modes
    run_win(1'b0, 1'b0, 16'hFFFF, 300);
    chk("R8 event busy sat", busy_cnt_o, 255);
    chk("R8 event win sat", win_len_o, 255);
    run_win(1'b1, 1'b1, 16'hFFFF, 300);
    chk("R8 span busy sat", busy_cnt_o, 255);
    chk("R8 span win sat", win_len_o, 255);

    // R9 R10: occupancy
    cap_i = 8'd100; occ_i = 8'd5;
    @(negedge clk_i);
    chk("R9 cur 5", cur_occ_o, 5);
    chk("R10 peak 5", peak_occ_o, 5);
    occ_i = 8'd20;
    @(negedge clk_i);
    occ_i = 8'd9;
    @(negedge clk_i);
    chk("R9 cur 9", cur_occ_o, 9);
    chk("R10 peak held 20", peak_occ_o, 20);
    cap_i = 8'd50; occ_i = 8'd200;
    @(negedge clk_i);
    chk("R9 clamp", cur_occ_o, 50);
    chk("R10 peak clamp", peak_occ_o, 50);
    occ_i = 8'd7; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R10 restart", peak_occ_o, 7);
    chk("R9 cur 7", cur_occ_o, 7);
    stop_i = 1'b1;
    @(negedge clk_i);
    stop_i = 1'b0;

    finish_run();
  end
endmodule